// File: doc/BRIEF.md
# One-Time Fuse Program and Read Controller

This block sits between a host register bus and a one-time-programmable fuse store. The host uses it to blow single fuse bits and to read 32-bit fuse rows. The fuse store is reached through two internal ports. One is a single-cycle set request that names one bit. The other is a combinational row-read port: the controller drives a row select and the store returns that row's contents in the same cycle.

A key-protected lock guards every other register against writes. A program request first remaps the array number. It then runs a fixed chain of permission checks, in this order:

- the array is valid;
- the lock is open;
- programming is enabled;
- the helper-data lock fuse is not blown (for arrays 2 and 3);
- the key-region lock fuse is not blown (for key rows).

Only then does the controller issue the set request. A read request is filtered by a per-row column mask, and a denied read returns zero. Each outcome is recorded in a write-one-to-clear status register. A mask register, changed only through separate enable and disable registers, selects which status bits drive the level interrupt.

The register word addresses on `host_addr_i` are:

| Address | Register |
|---|---|
| 0 | lock |
| 1 | config |
| 2 | program address |
| 3 | read address |
| 4 | read data |
| 5 | status |
| 6 | mask |
| 7 | enable |
| 8 | disable |

Top module: `efuse_ctrl`

## Requirements
- R1: The lock register (address 0, read back in bit 0) resets to 1. Writing 0x0000DF0D clears it, and writing any other value sets it. While it is 1, host writes to every other address are dropped.
- R2: A program address word carries the array in bits 12:11, the row in bits 10:5 and the column in bits 4:0. An accepted request blows exactly the bit {physical array, row, column}, which is index row*32+column within its array.
- R3: Logical array 0 maps to physical array 0, and logical arrays 2 and 3 map to physical arrays 1 and 2. Programming logical array 1 fails and issues no set request.
- R4: A program request fails in any of these cases: the lock is set when it executes; config bit 1 (program enable) is 0; or the target is logical array 2 or 3 while the fuse at array 0, row 21, column 30 is blown.
- R5: While the fuse at array 0, row 22, column 1 is blown, programming any column of array 0 rows 24 to 31 fails. The same rows in the other arrays are unaffected.
- R6: Every program attempt sets status bit 0 two clock edges after the address write. Bit 1 is set on failure and cleared on success. The set request is a single-cycle pulse, issued in that same cycle, and only on success.
- R7: Reads of array 0 keep only a per-row column mask: row 0 keeps bits 31:28; rows 8-15, 20, 22, 23 and 40-63 keep all bits; row 16 keeps bits 16:10 and 7:0; row 17 keeps bits 2:0; row 21 keeps bits 31:29 and 23:0. Every other row is denied.
- R8: A read of logical array 2 or 3 returns the full row of physical array 2 or 3 minus one. A read of logical array 1 is denied.
- R9: The read result (data at address 4) and the read status are due one clock edge after the read address write. A denied read returns 0, sets status bit 3 and clears bit 2. A permitted read clears bit 3 and sets bit 2.
- R10: Status bits 31 and 4:0 clear when written with 1. Writing 0 leaves them, and the other status bits always read 0.
- R11: The mask register resets to 0x8000001F and ignores direct writes. A write to address 7 ORs bits into it, and a write to address 8 clears bits from it. The interrupt output is high when any status bit is set whose mask bit is also set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| host_we_i | input | 1 | Host register write strobe |
| host_addr_i | input | 4 | Host register word address (read and write) |
| host_wdata_i | input | 32 | Host write data |
| host_rdata_o | output | 32 | Combinational read-back of the addressed register |
| fuse_rd_sel_o | output | 8 | Row select to the fuse store, {physical array, row} |
| fuse_rd_row_i | input | 32 | Contents of the selected fuse row |
| fuse_set_o | output | 1 | Single-cycle request to blow one fuse bit |
| fuse_set_bit_o | output | 13 | Bit to blow, {physical array, row, column} |
| irq_o | output | 1 | Level interrupt |

## Verification
Let edge E be the clock edge that takes a read-address write. Read data and read status change at E+1. For a program-address write at edge E, the helper-data lock fuse row is sampled at E+1. The status and the set pulse appear at E+2, and the fuse store takes the new bit at E+3. The bench writes on one falling edge and then samples on the falling edges that follow, so every check lands in the half-cycle after the edge that should have changed the value. A directed case also confirms that the program status is still clear one edge early. Each decision is compared against a shadow fuse array that the bench updates only when its own model predicts acceptance.

// File: rtl/efc_pkg.sv
package efc_pkg;
    localparam int ARR_W  = 2;
    localparam int ROW_W  = 6;
    localparam int COL_W  = 5;
    localparam int DATA_W = 32;
    localparam int REG_AW = 4;
    localparam int BIT_W  = ARR_W + ROW_W + COL_W;
    localparam int SEL_W  = ARR_W + ROW_W;

    localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'h0000_DF0D;
    localparam logic [DATA_W-1:0] IRQ_BITS   = 32'h8000_001F;

    localparam logic [REG_AW-1:0] A_LOCK = 4'd0;
    localparam logic [REG_AW-1:0] A_CFG  = 4'd1;
    localparam logic [REG_AW-1:0] A_PGM  = 4'd2;
    localparam logic [REG_AW-1:0] A_RDA  = 4'd3;
    localparam logic [REG_AW-1:0] A_RDD  = 4'd4;
    localparam logic [REG_AW-1:0] A_ISR  = 4'd5;
    localparam logic [REG_AW-1:0] A_IMR  = 4'd6;
    localparam logic [REG_AW-1:0] A_IER  = 4'd7;
    localparam logic [REG_AW-1:0] A_IDR  = 4'd8;

    localparam int CFG_PE     = 1;
    localparam int ST_PG_DONE = 0;
    localparam int ST_PG_ERR  = 1;
    localparam int ST_RD_DONE = 2;
    localparam int ST_RD_ERR  = 3;

    localparam int PUF_LK_ROW = 21;
    localparam int PUF_LK_COL = 30;
    localparam int AES_LK_ROW = 22;
    localparam int AES_LK_COL = 1;
    localparam int AES_ROW_LO = 24;
    localparam int AES_ROW_HI = 31;

    typedef enum logic [1:0] {PH_IDLE, PH_PG_A, PH_PG_B, PH_RD} phase_e;

    typedef struct packed {
        logic              lock;
        logic              pgm_en;
        logic [BIT_W-1:0]  pgm_addr;
        logic [SEL_W-1:0]  rd_addr;
        logic [DATA_W-1:0] rd_data;
        logic [DATA_W-1:0] isr;
        logic [DATA_W-1:0] imr;
        logic              pend_pg;
        logic              pend_rd;
        logic              puf_lk;
        phase_e            phase;
        logic              set_req;
        logic [BIT_W-1:0]  set_bit;
    } state_t;
endpackage

// File: rtl/efc_pgm_check.sv
module efc_pgm_check
    import efc_pkg::*;
(
    input  logic [BIT_W-1:0] addr_i,
    input  logic             lock_i,
    input  logic             pgm_en_i,
    input  logic             puf_lk_i,
    input  logic             aes_lk_i,
    output logic             ok_o,
    output logic [BIT_W-1:0] phys_o
);
    logic [ARR_W-1:0] arr;
    logic [ROW_W-1:0] row;
    logic [ARR_W-1:0] parr;
    logic             upper;
    logic             key_row;

    assign arr = addr_i[BIT_W-1 -: ARR_W];
    assign row = addr_i[COL_W +: ROW_W];

    always_comb begin
        upper   = (arr >= ARR_W'(2));
        parr    = upper ? (arr - 1'b1) : arr;
        phys_o  = {parr, row, addr_i[COL_W-1:0]};
        key_row = (arr == '0) && (row >= ROW_W'(AES_ROW_LO)) && (row <= ROW_W'(AES_ROW_HI));
        // ordered permission chain; the first failing stage decides
        if (arr == ARR_W'(1))         ok_o = 1'b0;
        else if (lock_i)              ok_o = 1'b0;
        else if (!pgm_en_i)           ok_o = 1'b0;
        else if (upper && puf_lk_i)   ok_o = 1'b0;
        else if (key_row && aes_lk_i) ok_o = 1'b0;
        else                          ok_o = 1'b1;
    end
endmodule

// File: rtl/efc_rd_filter.sv
module efc_rd_filter
    import efc_pkg::*;
(
    input  logic [SEL_W-1:0]  addr_i,
    input  logic [DATA_W-1:0] row_i,
    output logic [SEL_W-1:0]  sel_o,
    output logic [DATA_W-1:0] data_o,
    output logic              deny_o
);
    logic [ARR_W-1:0]  arr;
    logic [ROW_W-1:0]  row;
    logic [DATA_W-1:0] mask;

    assign arr = addr_i[SEL_W-1 -: ARR_W];
    assign row = addr_i[ROW_W-1:0];

    function automatic logic [DATA_W-1:0] base_mask(input logic [ROW_W-1:0] r);
        logic [DATA_W-1:0] m;
        m = '0;
        if (r == 6'd0)                                   m = 32'hF000_0000;
        else if (r inside {[6'd8:6'd15], 6'd20, 6'd22, 6'd23, [6'd40:6'd63]})
                                                         m = '1;
        else if (r == 6'd16)                             m = 32'h0001_FCFF;
        else if (r == 6'd17)                             m = 32'h0000_0007;
        else if (r == 6'd21)                             m = 32'hE0FF_FFFF;
        return m;
    endfunction

    always_comb begin
        if (arr == '0) begin
            sel_o = {arr, row};
            mask  = base_mask(row);
        end else if (arr >= ARR_W'(2)) begin
            sel_o = {arr - 1'b1, row};
            mask  = '1;
        end else begin
            sel_o = {arr, row};
            mask  = '0;
        end
        deny_o = (mask == '0);
        data_o = row_i & mask;
    end
endmodule

// File: rtl/efuse_ctrl.sv
module efuse_ctrl
    import efc_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              host_we_i,
    input  logic [REG_AW-1:0] host_addr_i,
    input  logic [DATA_W-1:0] host_wdata_i,
    output logic [DATA_W-1:0] host_rdata_o,
    output logic [SEL_W-1:0]  fuse_rd_sel_o,
    input  logic [DATA_W-1:0] fuse_rd_row_i,
    output logic              fuse_set_o,
    output logic [BIT_W-1:0]  fuse_set_bit_o,
    output logic              irq_o
);
    state_t s_d, s_q;

    logic              wr_ok;
    logic              pg_ok;
    logic [BIT_W-1:0]  pg_phys;
    logic [SEL_W-1:0]  rd_sel;
    logic [DATA_W-1:0] rd_val;
    logic              rd_deny;

    efc_pgm_check i_pgm_check (
        .addr_i   (s_q.pgm_addr),
        .lock_i   (s_q.lock),
        .pgm_en_i (s_q.pgm_en),
        .puf_lk_i (s_q.puf_lk),
        .aes_lk_i (fuse_rd_row_i[AES_LK_COL]),
        .ok_o     (pg_ok),
        .phys_o   (pg_phys)
    );

    efc_rd_filter i_rd_filter (
        .addr_i (s_q.rd_addr),
        .row_i  (fuse_rd_row_i),
        .sel_o  (rd_sel),
        .data_o (rd_val),
        .deny_o (rd_deny)
    );

    always_comb begin
        case (s_q.phase)
            PH_PG_A: fuse_rd_sel_o = {ARR_W'(0), ROW_W'(PUF_LK_ROW)};
            PH_PG_B: fuse_rd_sel_o = {ARR_W'(0), ROW_W'(AES_LK_ROW)};
            default: fuse_rd_sel_o = rd_sel;
        endcase
    end

    always_comb begin
        s_d         = s_q;
        s_d.set_req = 1'b0;
        wr_ok       = host_we_i && ((host_addr_i == A_LOCK) || !s_q.lock);
        if (wr_ok) begin
            case (host_addr_i)
                A_LOCK: s_d.lock = (host_wdata_i != UNLOCK_KEY);
                A_CFG:  s_d.pgm_en = host_wdata_i[CFG_PE];
                A_PGM: begin
                    s_d.pgm_addr = host_wdata_i[BIT_W-1:0];
                    s_d.pend_pg  = 1'b1;
                end
                A_RDA: begin
                    s_d.rd_addr = host_wdata_i[BIT_W-1:COL_W];
                    s_d.pend_rd = 1'b1;
                end
                A_ISR:  s_d.isr = s_q.isr & ~(host_wdata_i & IRQ_BITS);
                A_IER:  s_d.imr = s_q.imr | (host_wdata_i & IRQ_BITS);
                A_IDR:  s_d.imr = s_q.imr & ~(host_wdata_i & IRQ_BITS);
                default: ;
            endcase
        end
        // hardware status updates follow the host clear, so they win on a tie
        case (s_q.phase)
            PH_IDLE: begin
                if (s_d.pend_pg) begin
                    s_d.phase   = PH_PG_A;
                    s_d.pend_pg = 1'b0;
                end else if (s_d.pend_rd) begin
                    s_d.phase   = PH_RD;
                    s_d.pend_rd = 1'b0;
                end
            end
            PH_PG_A: begin
                s_d.puf_lk = fuse_rd_row_i[PUF_LK_COL];
                s_d.phase  = PH_PG_B;
            end
            PH_PG_B: begin
                s_d.isr[ST_PG_DONE] = 1'b1;
                s_d.isr[ST_PG_ERR]  = !pg_ok;
                s_d.set_req         = pg_ok;
                s_d.set_bit         = pg_phys;
                s_d.phase           = PH_IDLE;
            end
            default: begin
                s_d.rd_data         = rd_val;
                s_d.isr[ST_RD_DONE] = !rd_deny;
                s_d.isr[ST_RD_ERR]  = rd_deny;
                s_d.phase           = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q        <= '0;
            s_q.lock   <= 1'b1;
            s_q.imr    <= IRQ_BITS;
            s_q.phase  <= PH_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        case (host_addr_i)
            A_LOCK:  host_rdata_o = {{(DATA_W-1){1'b0}}, s_q.lock};
            A_CFG:   host_rdata_o = {{(DATA_W-2){1'b0}}, s_q.pgm_en, 1'b0};
            A_PGM:   host_rdata_o = {{(DATA_W-BIT_W){1'b0}}, s_q.pgm_addr};
            A_RDA:   host_rdata_o = {{(DATA_W-BIT_W){1'b0}}, s_q.rd_addr, {COL_W{1'b0}}};
            A_RDD:   host_rdata_o = s_q.rd_data;
            A_ISR:   host_rdata_o = s_q.isr;
            A_IMR:   host_rdata_o = s_q.imr;
            default: host_rdata_o = '0;
        endcase
    end

    assign fuse_set_o     = s_q.set_req;
    assign fuse_set_bit_o = s_q.set_bit;
    assign irq_o          = |(s_q.isr & s_q.imr);
endmodule

// File: rtl/efuse_ctrl_chk.sv
module efuse_ctrl_chk
    import efc_pkg::*;
(
    input logic              clk_i,
    input logic              rst_ni,
    input logic              host_we_i,
    input logic [REG_AW-1:0] host_addr_i,
    input logic              lock_q,
    input logic              pgm_en_q,
    input logic [BIT_W-1:0]  pgm_addr_q,
    input logic [DATA_W-1:0] isr_q,
    input logic [DATA_W-1:0] imr_q,
    input logic [DATA_W-1:0] rd_data_q,
    input logic              in_rd,
    input logic              set_o,
    input logic [ARR_W-1:0]  set_arr
);
    // R1: a write to a non-lock register while locked leaves state unchanged
    assert_locked_drop_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (host_we_i && host_addr_i != A_LOCK && lock_q)
        |=> ($stable(pgm_en_q) && $stable(imr_q) && $stable(pgm_addr_q)));

    assert_no_arr3_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        set_o |-> (set_arr != 2'b11));

    assert_pulse_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        set_o |=> !set_o);

    assert_set_flags_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        set_o |-> (isr_q[ST_PG_DONE] && !isr_q[ST_PG_ERR]));

    assert_rd_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        in_rd |=> (isr_q[ST_RD_DONE] != isr_q[ST_RD_ERR]));

    assert_deny_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        in_rd |=> (!isr_q[ST_RD_ERR] || rd_data_q == '0));

    assert_isr_bits_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (isr_q & ~IRQ_BITS) == '0);

    assert_imr_bits_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (imr_q & ~IRQ_BITS) == '0);
endmodule

bind efuse_ctrl efuse_ctrl_chk i_efuse_ctrl_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .host_we_i   (host_we_i),
    .host_addr_i (host_addr_i),
    .lock_q      (s_q.lock),
    .pgm_en_q    (s_q.pgm_en),
    .pgm_addr_q  (s_q.pgm_addr),
    .isr_q       (s_q.isr),
    .imr_q       (s_q.imr),
    .rd_data_q   (s_q.rd_data),
    .in_rd       (s_q.phase == efc_pkg::PH_RD),
    .set_o       (fuse_set_o),
    .set_arr     (fuse_set_bit_o[12:11])
);

// File: tb/test_efuse_ctrl.sv
`timescale 1ns/1ps
module test_efuse_ctrl;
    localparam logic [3:0] R_LOCK = 4'd0, R_CFG = 4'd1, R_PGM = 4'd2, R_RDA = 4'd3,
                           R_RDD = 4'd4, R_ISR = 4'd5, R_IMR = 4'd6, R_IER = 4'd7,
                           R_IDR = 4'd8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [7:0]  rd_sel;
    logic [31:0] rd_row;
    logic        set_req;
    logic [12:0] set_bit;
    logic        irq;

    logic [31:0] fmem   [256];
    logic [31:0] shadow [256];
    int          pulses;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          pe = 1'b0;

    always #10 clk = ~clk;

    efuse_ctrl i_efuse_ctrl (
        .clk_i(clk), .rst_ni(rst_n), .host_we_i(we), .host_addr_i(addr),
        .host_wdata_i(wdata), .host_rdata_o(rdata), .fuse_rd_sel_o(rd_sel),
        .fuse_rd_row_i(rd_row), .fuse_set_o(set_req), .fuse_set_bit_o(set_bit),
        .irq_o(irq)
    );

    always_comb rd_row = fmem[rd_sel];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) fmem[i] <= '0;
            pulses <= 0;
        end else if (set_req) begin
            fmem[set_bit[12:5]][set_bit[4:0]] <= 1'b1;
            pulses <= pulses + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd_reg(input logic [3:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    function automatic logic [31:0] col_mask(input int row);
        if (row == 0) return 32'hF000_0000;
        if ((row >= 8 && row <= 15) || row == 20 || row == 22 || row == 23 || row >= 40)
            return 32'hFFFF_FFFF;
        if (row == 16) return 32'h0001_FCFF;
        if (row == 17) return 32'h0000_0007;
        if (row == 21) return 32'hE0FF_FFFF;
        return 32'h0;
    endfunction

    function automatic bit model_ok(input logic [12:0] w);
        int a = int'(w[12:11]);
        int r = int'(w[10:5]);
        if (a == 1) return 1'b0;
        if (!pe) return 1'b0;
        if (a >= 2 && shadow[21][30]) return 1'b0;
        if (a == 0 && r >= 24 && r <= 31 && shadow[22][1]) return 1'b0;
        return 1'b1;
    endfunction

    task automatic do_pgm(input logic [12:0] w);
        logic [31:0] v;
        int p0, a, idx;
        bit ok;
        string tag;
        a   = int'(w[12:11]);
        tag = (a == 1) ? "R3" : "R4";
        ok  = model_ok(w);
        idx = ((a >= 2) ? a - 1 : a) * 64 + int'(w[10:5]);
        wr_reg(R_ISR, 32'hFFFF_FFFF);
        p0 = pulses;
        wr_reg(R_PGM, {19'b0, w});
        repeat (3) @(negedge clk);
        rd_reg(R_ISR, v);
        chk({tag, " pgm status R6"}, v, {30'b0, !ok, 1'b1});
        chk({tag, " set pulse count R6"}, pulses - p0, {31'b0, ok});
        if (ok) shadow[idx][w[4:0]] = 1'b1;
        if (a != 1) chk("R2 fuse row content", fmem[idx], shadow[idx]);
    endtask

    task automatic do_rd(input logic [12:0] w);
        logic [31:0] v, expd, m;
        int a, r;
        bit deny;
        a = int'(w[12:11]);
        r = int'(w[10:5]);
        if (a == 0) m = col_mask(r);
        else if (a >= 2) m = 32'hFFFF_FFFF;
        else m = 32'h0;
        deny = (m == 0);
        expd = (a == 0 || a == 1) ? (shadow[r] & m) : shadow[(a - 1) * 64 + r];
        wr_reg(R_ISR, 32'hFFFF_FFFF);
        wr_reg(R_RDA, {19'b0, w});
        @(negedge clk);
        rd_reg(R_RDD, v);
        chk((a == 0) ? "R7 masked data" : "R8 remapped data", v, expd);
        rd_reg(R_ISR, v);
        chk("R9 read status", v, {28'b0, deny, !deny, 2'b00});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int p0;
        for (int i = 0; i < 256; i++) shadow[i] = '0;
        void'($urandom(32'd24681357));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        rd_reg(R_LOCK, v); chk("R1 lock reset", v, 32'h1);
        rd_reg(R_IMR, v);  chk("R11 mask reset", v, 32'h8000_001F);
        rd_reg(R_ISR, v);  chk("R10 status reset", v, 32'h0);
        chk("R11 irq reset", {31'b0, irq}, 32'h0);
        chk("R6 no set at reset", {31'b0, set_req}, 32'h0);

        // lock behaviour
        wr_reg(R_CFG, 32'h2);
        rd_reg(R_CFG, v);  chk("R1 locked write dropped", v, 32'h0);
        wr_reg(R_LOCK, 32'h0000_1234);
        rd_reg(R_LOCK, v); chk("R1 wrong key keeps lock", v, 32'h1);
        wr_reg(R_LOCK, 32'h0000_DF0D);
        rd_reg(R_LOCK, v); chk("R1 key unlocks", v, 32'h0);
        wr_reg(R_CFG, 32'h2); pe = 1'b1;
        rd_reg(R_CFG, v);  chk("R1 unlocked write taken", v, 32'h2);

        // program timing and single pulse
        wr_reg(R_ISR, 32'hFFFF_FFFF);
        wr_reg(R_PGM, {19'b0, 2'd0, 6'd0, 5'd28});
        @(negedge clk);
        rd_reg(R_ISR, v); chk("R6 status not early", v, 32'h0);
        @(negedge clk);
        rd_reg(R_ISR, v); chk("R6 status on time", v, 32'h1);
        chk("R6 set pulse on time", {31'b0, set_req}, 32'h1);
        chk("R2 set bit index", {19'b0, set_bit}, {19'b0, 2'd0, 6'd0, 5'd28});
        @(negedge clk);
        chk("R6 set pulse single", {31'b0, set_req}, 32'h0);
        shadow[0][28] = 1'b1;
        do_pgm({2'd0, 6'd0, 5'd3});
        do_rd({2'd0, 6'd0, 5'd0});      // R7: row 0 keeps only 31:28
        do_pgm({2'd1, 6'd5, 5'd5});     // R3: logical array 1 rejected
        do_rd({2'd1, 6'd5, 5'd0});      // R8: array 1 denied

        // program enable off
        wr_reg(R_CFG, 32'h0); pe = 1'b0;
        do_pgm({2'd0, 6'd9, 5'd1});     // R4
        wr_reg(R_CFG, 32'h2); pe = 1'b1;

        // status write-one-to-clear of a single bit
        do_pgm({2'd1, 6'd0, 5'd0});
        wr_reg(R_ISR, 32'h1);
        rd_reg(R_ISR, v); chk("R10 w1c single bit", v, 32'h2);
        wr_reg(R_ISR, 32'h0);
        rd_reg(R_ISR, v); chk("R10 zero write keeps", v, 32'h2);

        // interrupt mask
        wr_reg(R_IDR, 32'hFFFF_FFFF);
        rd_reg(R_IMR, v); chk("R11 disable clears mask", v, 32'h0);
        chk("R11 irq masked", {31'b0, irq}, 32'h0);
        wr_reg(R_IMR, 32'h0000_0002);
        rd_reg(R_IMR, v); chk("R11 mask ignores direct write", v, 32'h0);
        wr_reg(R_IER, 32'h0000_0002);
        chk("R11 irq on enable", {31'b0, irq}, 32'h1);
        wr_reg(R_IER, 32'h8000_001D);
        rd_reg(R_IMR, v); chk("R11 enable ORs", v, 32'h8000_001F);
        wr_reg(R_ISR, 32'hFFFF_FFFF);
        chk("R11 irq after clear", {31'b0, irq}, 32'h0);

        // relock: program write dropped
        wr_reg(R_LOCK, 32'h5);
        p0 = pulses;
        wr_reg(R_PGM, {19'b0, 2'd0, 6'd10, 5'd7});
        repeat (4) @(negedge clk);
        rd_reg(R_ISR, v); chk("R1 locked program ignored", v, 32'h0);
        chk("R1 no pulse when locked", pulses - p0, 32'h0);
        wr_reg(R_LOCK, 32'h0000_DF0D);

        // random mix
        for (int it = 0; it < 240; it++) begin
            int unsigned r = $urandom;
            logic [12:0] w = 13'($urandom);
            if (r % 9 == 0) begin
                pe = ~pe;
                wr_reg(R_CFG, {30'b0, pe, 1'b0});
            end
            if (r % 3 != 0) do_pgm(w);
            else do_rd(w);
        end
        wr_reg(R_CFG, 32'h2); pe = 1'b1;

        // key-region lock fuse
        do_pgm({2'd0, 6'd26, 5'd5});
        do_pgm({2'd0, 6'd22, 5'd1});
        do_pgm({2'd0, 6'd27, 5'd6});    // R5 blocked
        chk("R5 key rows blocked", {31'b0, model_ok({2'd0, 6'd27, 5'd6})}, 32'h0);
        do_pgm({2'd0, 6'd23, 5'd6});
        do_pgm({2'd2, 6'd27, 5'd6});    // R5 other arrays unaffected
        do_rd({2'd0, 6'd22, 5'd0});

        // helper-data lock fuse
        do_pgm({2'd2, 6'd3, 5'd4});
        do_pgm({2'd0, 6'd21, 5'd30});
        do_pgm({2'd2, 6'd3, 5'd9});     // R4 blocked
        do_pgm({2'd3, 6'd3, 5'd9});     // R4 blocked
        chk("R4 helper lock blocks", {31'b0, model_ok({2'd3, 6'd3, 5'd9})}, 32'h0);
        do_pgm({2'd0, 6'd12, 5'd9});
        do_rd({2'd0, 6'd21, 5'd0});     // R7 row 21 mask
        do_rd({2'd2, 6'd3, 5'd0});      // R8 full row
        do_rd({2'd3, 6'd27, 5'd0});
        do_rd({2'd0, 6'd5, 5'd0});      // R7 denied row

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule